// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Router

This block collects interrupt requests from up to 64 device sources and routes them to up to four processors. It keeps one shared pending-request vector, which devices set and clear through single-source post and clear events. Each processor has its own enable mask, written by software. A processor's active set is its mask ANDed with the pending vector. Each processor has a level interrupt output that is high while its active set is non-empty, and a source number that names the lowest active source.

Software reaches the registers through a 64-bit register port. The register number is the byte offset from a base address shifted right by six, so each register owns a 64-byte slot. The registers are the per-CPU masks, which can be read and written, and the per-CPU active sets and the pending vector, which can only be read. The routing events go out as one-cycle per-source pulse vectors for each CPU. When a mask is written, pulses go out only for the sources the write actually turns on or off. When a device posts, the source is re-announced to every CPU that has it enabled.

Top module: `irq_mask_router`

## Requirements
- R1: The register number is (address − BASE_ADDR) >> 6, and address bits [5:0] are ignored. Slots 0..3 hold the masks of CPU 0..3, slots 4..7 hold their active sets, and slot 8 holds the pending vector. A read returns the value in `reg_rdata` one cycle after `reg_rd`, with `reg_err` low.
- R2: A legal write to slot n (n < 4) replaces the whole mask of CPU n. The active set of CPU n then reads as the new mask AND the pending vector.
- R3: A mask write to CPU n pulses `post_pulse[n*64+x]` for one cycle, in the cycle after the write, for each source x that the write turns from 0 to 1 and whose pending bit is set.
- R4: A mask write to CPU n pulses `clr_pulse[n*64+x]` for one cycle, in the cycle after the write, for each source x that was active before the write and is not active after it.
- R5: A post event (`dev_valid`=1, `dev_set`=1) for source k sets pending bit k. In the next cycle it pulses `post_pulse` bit k on every CPU whose mask has bit k set, even if bit k was already pending.
- R6: A clear event (`dev_valid`=1, `dev_set`=0) for source k with pending bit k set clears that bit. In the next cycle it pulses `clr_pulse` bit k on every CPU whose active bit k was set. If pending bit k is already 0, the event changes no state and produces no pulse.
- R7: A write to slots 4..8 drives `reg_err` high for one cycle, one cycle later, and changes no mask and no pending bit.
- R8: An access with `reg_size` other than 3 (3 means 8 bytes; 0, 1 and 2 mean 1, 2 and 4 bytes), an address below BASE_ADDR, or a slot above 8 drives `reg_err` high one cycle later. Such an access changes nothing, and a read of this kind returns 0.
- R9: `cpu_irq[n]` is high exactly when the active set of CPU n is non-zero. In that case `cpu_vec[n*6 +: 6]` is the lowest-numbered active source; otherwise it is 0.
- R10: A synchronous active-low reset clears every mask, the pending vector, every pulse, `reg_err` and `reg_rdata`.
- R11: When a device event and a mask write arrive in the same cycle, the pending vector is updated first. The write's comparison uses the updated pending vector, and the device post pulse uses the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_size | input | 2 | Access size code, 3 = 8 bytes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the read |
| reg_err | output | 1 | Illegal-access pulse, one cycle after the access |
| dev_valid | input | 1 | Device event strobe |
| dev_set | input | 1 | 1 = post, 0 = clear |
| dev_src | input | SRC_W | Source number of the event |
| cpu_irq | output | NUM_CPU | Per-CPU interrupt level |
| cpu_vec | output | NUM_CPU*SRC_W | Per-CPU lowest active source |
| post_pulse | output | NUM_CPU*NUM_SRC | Per-CPU, per-source post events |
| clr_pulse | output | NUM_CPU*NUM_SRC | Per-CPU, per-source clear events |

## Verification
The bench builds the block with its default parameters: four CPUs, 64 sources, a 16-bit address and a base of 0x1000. This places the pending vector in slot 8 and makes source 63, the top bit of a full 64-bit word, reachable. With these values, every slot boundary can be tested: the last mask slot, the first read-only slot, the first unmapped slot and the address just below the base. The selective post and clear of a mask write is exercised on full-width masks that overlap on several sources at once. The tests also cover the spurious clear and the same-cycle write and device event.

// File: rtl/irqr_pkg.sv
// Shared constants and types for the interrupt mask router.
// Assumes a 64-bit register word and 64-byte register slots.
package irqr_pkg;
    localparam int WORD_W     = 64;
    localparam int SLOT_SHIFT = 6;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ACC_1B = 2'd0,
        ACC_2B = 2'd1,
        ACC_4B = 2'd2,
        ACC_8B = 2'd3
    } acc_size_e;
endpackage

// File: rtl/irqr_lowbit.sv
// Finds the lowest set bit of a vector.
// Assumes N >= 2. index is 0 when no bit is set.
module irqr_lowbit #(
    parameter int N = 64,
    parameter int W = 6
) (
    input  logic [N-1:0] bits,
    output logic         found,
    output logic [W-1:0] index
);
    // Priority search: the last match in a top-down scan is the lowest set bit.
    always_comb begin
        found = |bits;
        index = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) begin
                index = W'(i);
            end
        end
    end
endmodule

// File: rtl/irqr_regport.sv
// Register port of the router: decodes slot numbers, flags illegal
// accesses and returns read data one cycle after the strobe.
// Assumes the slots are masks, then active sets, then the pending vector.
module irqr_regport
    import irqr_pkg::*;
#(
    parameter int          NUM_CPU   = 4,
    parameter int          NUM_SRC   = 64,
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h1000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [1:0]                 reg_size,
    input  logic [NUM_CPU*NUM_SRC-1:0] mask_flat,
    input  logic [NUM_CPU*NUM_SRC-1:0] active_flat,
    input  logic [NUM_SRC-1:0]         raw_q,
    output logic [NUM_CPU-1:0]         mask_we,
    output word_t                      reg_rdata,
    output logic                       reg_err
);
    localparam int ACT_IDX = NUM_CPU;
    localparam int RAW_IDX = 2 * NUM_CPU;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] slot;
    logic              below_base;
    logic              size_ok;
    logic              unmapped;
    logic              ro_hit;
    logic              bad;
    word_t             rd_word;

    // Slot decode and legality of the current access.
    always_comb begin
        below_base = reg_addr < ADDR_W'(BASE_ADDR);
        offset     = reg_addr - ADDR_W'(BASE_ADDR);
        slot       = offset >> SLOT_SHIFT;
        size_ok    = acc_size_e'(reg_size) == ACC_8B;
        unmapped   = below_base || (slot > ADDR_W'(RAW_IDX));
        ro_hit     = slot >= ADDR_W'(ACT_IDX);
        bad        = !size_ok || unmapped || (reg_wr && ro_hit);
    end

    // One write enable per CPU mask slot.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_we
        assign mask_we[c] = reg_wr && !bad && (slot == ADDR_W'(c));
    end

    // Read multiplexer over every readable slot.
    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (slot == ADDR_W'(c)) begin
                rd_word = WORD_W'(mask_flat[c*NUM_SRC +: NUM_SRC]);
            end
            if (slot == ADDR_W'(ACT_IDX + c)) begin
                rd_word = WORD_W'(active_flat[c*NUM_SRC +: NUM_SRC]);
            end
        end
        if (slot == ADDR_W'(RAW_IDX)) begin
            rd_word = WORD_W'(raw_q);
        end
    end

    // Registered read data and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            reg_err   <= 1'b0;
        end else begin
            reg_err   <= (reg_wr || reg_rd) && bad;
            reg_rdata <= (reg_rd && !bad) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/irqr_lane.sv
// One CPU's lane: holds the enable mask, derives the active set, and
// produces the registered post/clear pulses and the interrupt level.
// Assumes raw_n is the pending vector after this cycle's device event.
module irqr_lane #(
    parameter int NUM_SRC = 64,
    parameter int SRC_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] wr_mask,
    input  logic [NUM_SRC-1:0] raw_q,
    input  logic [NUM_SRC-1:0] raw_n,
    input  logic [NUM_SRC-1:0] post_hot,
    input  logic [NUM_SRC-1:0] clr_hot,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] active,
    output logic [NUM_SRC-1:0] post_q,
    output logic [NUM_SRC-1:0] clr_q,
    output logic               irq,
    output logic [SRC_W-1:0]   vec
);
    logic [NUM_SRC-1:0] mask_n;
    logic [NUM_SRC-1:0] wr_rise;
    logic [NUM_SRC-1:0] wr_drop;
    logic [NUM_SRC-1:0] post_d;
    logic [NUM_SRC-1:0] clr_d;

    // Next mask and the selective events from writes and device activity.
    always_comb begin
        active  = mask_q & raw_q;
        mask_n  = mask_we ? wr_mask : mask_q;
        wr_rise = mask_we ? (~mask_q & wr_mask & raw_n) : '0;
        wr_drop = mask_we ? (active & ~(wr_mask & raw_n)) : '0;
        post_d  = wr_rise | (post_hot & mask_n);
        clr_d   = wr_drop | (clr_hot & active);
    end

    // Mask storage and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            post_q <= '0;
            clr_q  <= '0;
        end else begin
            mask_q <= mask_n;
            post_q <= post_d;
            clr_q  <= clr_d;
        end
    end

    irqr_lowbit #(
        .N (NUM_SRC),
        .W (SRC_W)
    ) u_low (
        .bits  (active),
        .found (irq),
        .index (vec)
    );
endmodule

// File: rtl/irq_mask_router.sv
// Top of the per-CPU interrupt mask router. Holds the shared pending
// vector, applies device post/clear events and instantiates one lane
// per CPU plus the register port.
// Assumes at most one device event per cycle.
module irq_mask_router
    import irqr_pkg::*;
#(
    parameter int          NUM_CPU   = 4,
    parameter int          NUM_SRC   = 64,
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h1000,
    localparam int         SRC_W     = $clog2(NUM_SRC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [1:0]                 reg_size,
    input  logic [63:0]                reg_wdata,
    output logic [63:0]                reg_rdata,
    output logic                       reg_err,
    input  logic                       dev_valid,
    input  logic                       dev_set,
    input  logic [SRC_W-1:0]           dev_src,
    output logic [NUM_CPU-1:0]         cpu_irq,
    output logic [NUM_CPU*SRC_W-1:0]   cpu_vec,
    output logic [NUM_CPU*NUM_SRC-1:0] post_pulse,
    output logic [NUM_CPU*NUM_SRC-1:0] clr_pulse
);
    logic [NUM_SRC-1:0]         raw_q;
    logic [NUM_SRC-1:0]         raw_n;
    logic [NUM_SRC-1:0]         src_hot;
    logic [NUM_SRC-1:0]         post_hot;
    logic [NUM_SRC-1:0]         clr_hot;
    logic [NUM_CPU*NUM_SRC-1:0] mask_flat;
    logic [NUM_CPU*NUM_SRC-1:0] active_flat;
    logic [NUM_CPU-1:0]         mask_we;

    // Decode the device event; a clear only acts on a pending source.
    always_comb begin
        src_hot  = NUM_SRC'(1) << dev_src;
        post_hot = (dev_valid && dev_set) ? src_hot : '0;
        clr_hot  = (dev_valid && !dev_set) ? (src_hot & raw_q) : '0;
        raw_n    = (raw_q | post_hot) & ~clr_hot;
    end

    // Pending request storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= raw_n;
        end
    end

    irqr_regport #(
        .NUM_CPU   (NUM_CPU),
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_size    (reg_size),
        .mask_flat   (mask_flat),
        .active_flat (active_flat),
        .raw_q       (raw_q),
        .mask_we     (mask_we),
        .reg_rdata   (reg_rdata),
        .reg_err     (reg_err)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
        irqr_lane #(
            .NUM_SRC (NUM_SRC),
            .SRC_W   (SRC_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .mask_we  (mask_we[c]),
            .wr_mask  (reg_wdata[NUM_SRC-1:0]),
            .raw_q    (raw_q),
            .raw_n    (raw_n),
            .post_hot (post_hot),
            .clr_hot  (clr_hot),
            .mask_q   (mask_flat[c*NUM_SRC +: NUM_SRC]),
            .active   (active_flat[c*NUM_SRC +: NUM_SRC]),
            .post_q   (post_pulse[c*NUM_SRC +: NUM_SRC]),
            .clr_q    (clr_pulse[c*NUM_SRC +: NUM_SRC]),
            .irq      (cpu_irq[c]),
            .vec      (cpu_vec[c*SRC_W +: SRC_W])
        );
    end
endmodule

// File: rtl/irq_mask_router_chk.sv
// Property checker for the interrupt mask router, bound to the top.
// Assumes the slot layout and size code stated in the requirements.
module irq_mask_router_chk #(
    parameter int          NUM_CPU   = 4,
    parameter int          NUM_SRC   = 64,
    parameter int          ADDR_W    = 16,
    parameter int unsigned BASE_ADDR = 32'h1000,
    parameter int          SRC_W     = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [1:0]                 reg_size,
    input logic                       reg_err,
    input logic                       dev_valid,
    input logic                       dev_set,
    input logic [SRC_W-1:0]           dev_src,
    input logic [NUM_CPU-1:0]         cpu_irq,
    input logic [NUM_CPU*SRC_W-1:0]   cpu_vec,
    input logic [NUM_CPU*NUM_SRC-1:0] clr_pulse,
    input logic [NUM_SRC-1:0]         raw_q,
    input logic [NUM_CPU*NUM_SRC-1:0] mask_flat
);
    logic [ADDR_W-1:0] slot_c;
    logic              ro_write;
    logic              src_pending;

    // Independent slot decode for the legality properties.
    always_comb begin
        slot_c   = (reg_addr - ADDR_W'(BASE_ADDR)) >> 6;
        ro_write = reg_wr && (reg_size == 2'd3) && (reg_addr >= ADDR_W'(BASE_ADDR))
                   && (slot_c >= ADDR_W'(NUM_CPU)) && (slot_c <= ADDR_W'(2 * NUM_CPU));
        src_pending = ((raw_q >> dev_src) & NUM_SRC'(1)) != '0;
    end

    assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd) && (reg_size != 2'd3) |=> reg_err);

    assert_ro_write_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ro_write |=> reg_err);

    assert_ro_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ro_write && !dev_valid |=> $stable(mask_flat) && $stable(raw_q));

    assert_spurious_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_set && !src_pending && !reg_wr
        |=> $stable(raw_q) && (clr_pulse == '0));

    assert_post_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && dev_set && (int'(dev_src) < NUM_SRC)
        |=> ((raw_q >> $past(dev_src)) & NUM_SRC'(1)) != '0);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [NUM_SRC-1:0] act_c;
        logic [SRC_W-1:0]   vec_c;
        assign act_c = mask_flat[c*NUM_SRC +: NUM_SRC] & raw_q;
        assign vec_c = cpu_vec[c*SRC_W +: SRC_W];

        assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] == (act_c != '0));

        assert_vec_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> (act_c[vec_c] && ((act_c & ((NUM_SRC'(1) << vec_c) - NUM_SRC'(1))) == '0)));
    end
endmodule

bind irq_mask_router irq_mask_router_chk #(
    .NUM_CPU   (NUM_CPU),
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .SRC_W     (SRC_W)
) u_chk (.*);

// File: tb/irq_mask_router_tb.sv
`timescale 1ns/1ps
module irq_mask_router_tb;
    localparam int          NC   = 4;
    localparam int          NS   = 64;
    localparam int          AW   = 16;
    localparam int unsigned BASE = 32'h1000;
    localparam int          SW   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [1:0]        reg_size = 2'd3;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic              reg_err;
    logic              dev_valid = 1'b0;
    logic              dev_set = 1'b0;
    logic [SW-1:0]     dev_src = '0;
    logic [NC-1:0]     cpu_irq;
    logic [NC*SW-1:0]  cpu_vec;
    logic [NC*NS-1:0]  post_pulse;
    logic [NC*NS-1:0]  clr_pulse;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [63:0] m_mask [NC];
    logic [63:0] m_raw;

    always #2.5 clk = ~clk;

    irq_mask_router #(
        .NUM_CPU (NC), .NUM_SRC (NS), .ADDR_W (AW), .BASE_ADDR (BASE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_addr (reg_addr), .reg_size (reg_size), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .reg_err (reg_err), .dev_valid (dev_valid),
        .dev_set (dev_set), .dev_src (dev_src), .cpu_irq (cpu_irq),
        .cpu_vec (cpu_vec), .post_pulse (post_pulse), .clr_pulse (clr_pulse)
    );

    // Stimulus table: {op[1:0], cpu[1:0], src[5:0], data[63:0]}; op 0 = mask write, 1 = post, 2 = clear
    localparam logic [73:0] TBL [14] = '{
        {2'd0, 2'd0, 6'd0,  64'h0000_0000_0000_000F},
        {2'd1, 2'd0, 6'd2,  64'h0},
        {2'd1, 2'd0, 6'd40, 64'h0},
        {2'd0, 2'd1, 6'd0,  64'h0000_0100_0000_0004},
        {2'd0, 2'd2, 6'd0,  64'hFFFF_FFFF_FFFF_FFFF},
        {2'd1, 2'd0, 6'd2,  64'h0},
        {2'd2, 2'd0, 6'd2,  64'h0},
        {2'd2, 2'd0, 6'd2,  64'h0},
        {2'd0, 2'd1, 6'd0,  64'h0},
        {2'd0, 2'd3, 6'd0,  64'h8000_0000_0000_0000},
        {2'd1, 2'd0, 6'd63, 64'h0},
        {2'd1, 2'd0, 6'd0,  64'h0},
        {2'd0, 2'd2, 6'd0,  64'h8000_0100_0000_0000},
        {2'd2, 2'd0, 6'd40, 64'h0}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int idx);
        return AW'(BASE + 64 * idx);
    endfunction

    function automatic logic [63:0] model_reg(input int idx);
        if (idx < NC) return m_mask[idx];
        if (idx < 2 * NC) return m_mask[idx-NC] & m_raw;
        return m_raw;
    endfunction

    task automatic chk_levels(input string tag);
        for (int cc = 0; cc < NC; cc++) begin
            logic [63:0] a;
            logic [SW-1:0] v;
            a = m_mask[cc] & m_raw;
            v = '0;
            for (int i = NS - 1; i >= 0; i--) if (a[i]) v = SW'(i);
            chk(cpu_irq[cc] === (a != 0), {tag, " R9 irq"}, 64'(cpu_irq[cc]), 64'(a != 0));
            chk(cpu_vec[cc*SW +: SW] === v, {tag, " R9 vec"}, 64'(cpu_vec[cc*SW +: SW]), 64'(v));
        end
    endtask

    task automatic rd_chk(input logic [AW-1:0] addr, input logic [63:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = addr; reg_size = 2'd3;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        chk(reg_rdata === exp, {tag, " R1 rdata"}, reg_rdata, exp);
        chk(reg_err === 1'b0, {tag, " R1 err"}, 64'(reg_err), 64'd0);
    endtask

    task automatic chk_all_regs(input string tag);
        for (int i = 0; i <= 2 * NC; i++) rd_chk(addr_of(i), model_reg(i), tag);
    endtask

    // One cycle of stimulus: optional mask write and optional device event
    task automatic step(input bit wr, input int c, input logic [63:0] d,
                        input bit dv, input bit ds, input int k, input string tag);
        logic [63:0] raw_n, mn, ep, ec;
        logic [63:0] e_post [NC];
        logic [63:0] e_clr [NC];
        logic [63:0] n_mask [NC];
        raw_n = m_raw;
        if (dv) begin
            if (ds) raw_n[k] = 1'b1;
            else if (m_raw[k]) raw_n[k] = 1'b0;
        end
        for (int cc = 0; cc < NC; cc++) begin
            mn = (wr && cc == c) ? d : m_mask[cc];
            ep = '0; ec = '0;
            if (wr && cc == c) begin
                ep = ~m_mask[cc] & d & raw_n;
                ec = (m_mask[cc] & m_raw) & ~(d & raw_n);
            end
            if (dv && ds) ep[k] = ep[k] | mn[k];
            if (dv && !ds && m_raw[k]) ec[k] = ec[k] | m_mask[cc][k];
            e_post[cc] = ep; e_clr[cc] = ec; n_mask[cc] = mn;
        end
        reg_wr = wr; reg_addr = addr_of(c); reg_size = 2'd3; reg_wdata = d;
        dev_valid = dv; dev_set = ds; dev_src = SW'(k);
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; dev_valid = 1'b0;
        for (int cc = 0; cc < NC; cc++) begin
            chk(post_pulse[cc*NS +: NS] === e_post[cc], {tag, " post"}, post_pulse[cc*NS +: NS], e_post[cc]);
            chk(clr_pulse[cc*NS +: NS] === e_clr[cc], {tag, " clr"}, clr_pulse[cc*NS +: NS], e_clr[cc]);
            m_mask[cc] = n_mask[cc];
        end
        chk(reg_err === 1'b0, {tag, " R8 no err"}, 64'(reg_err), 64'd0);
        m_raw = raw_n;
        chk_levels(tag);
    endtask

    task automatic err_access(input bit wr, input logic [AW-1:0] addr, input logic [1:0] sz, input string tag);
        reg_wr = wr; reg_rd = !wr; reg_addr = addr; reg_size = sz; reg_wdata = '1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_size = 2'd3;
        chk(reg_err === 1'b1, {tag, " err"}, 64'(reg_err), 64'd1);
        if (!wr) chk(reg_rdata === '0, {tag, " rdata zero"}, reg_rdata, 64'd0);
        chk(post_pulse === '0 && clr_pulse === '0, {tag, " no pulse"}, 64'(|post_pulse), 64'd0);
        chk_all_regs({tag, " unchanged"});
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cc = 0; cc < NC; cc++) m_mask[cc] = '0;
        m_raw = '0;
        chk(post_pulse === '0 && clr_pulse === '0, {tag, " R10 pulses"}, 64'(|post_pulse | |clr_pulse), 64'd0);
        chk(reg_err === 1'b0 && reg_rdata === '0, {tag, " R10 port"}, reg_rdata, 64'd0);
        chk(cpu_irq === '0, {tag, " R10 irq"}, 64'(cpu_irq), 64'd0);
        chk_all_regs({tag, " R10 regs"});
    endtask

    initial begin
        @(negedge clk);
        do_reset("reset");

        for (int i = 0; i < 14; i++) begin
            logic [73:0] e;
            e = TBL[i];
            case (e[73:72])
                2'd0: step(1'b1, int'(e[71:70]), e[63:0], 1'b0, 1'b0, 0, "R2/R3/R4 mask write");
                2'd1: step(1'b0, 0, 64'h0, 1'b1, 1'b1, int'(e[69:64]), "R5 device post");
                default: step(1'b0, 0, 64'h0, 1'b1, 1'b0, int'(e[69:64]), "R6 device clear");
            endcase
            chk_all_regs("R2 readback");
        end

        // Read-only slots reject writes
        err_access(1'b1, addr_of(5), 2'd3, "R7 active write");
        err_access(1'b1, addr_of(8), 2'd3, "R7 pending write");
        // Illegal size, unmapped slot, below base
        err_access(1'b1, addr_of(0), 2'd2, "R8 size write");
        err_access(1'b0, addr_of(8), 2'd1, "R8 size read");
        err_access(1'b0, addr_of(9), 2'd3, "R8 unmapped slot");
        err_access(1'b0, AW'(BASE - 64), 2'd3, "R8 below base");
        // Low address bits inside a slot are ignored
        rd_chk(addr_of(1) + AW'(8), m_mask[1], "R1 offset in slot");
        rd_chk(addr_of(6) + AW'(63), m_mask[2] & m_raw, "R1 slot top byte");

        // Same-cycle write and device event: pending updated first
        step(1'b1, 1, 64'h20, 1'b1, 1'b1, 5, "R11 write with post");
        step(1'b1, 0, 64'h2, 1'b1, 1'b1, 1, "R11 write drop and post");
        step(1'b1, 3, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 63, "R11 write with clear");
        chk_all_regs("R11 readback");

        do_reset("mid reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R10 actual=%h expected=%h", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule